// File: doc/BRIEF.md
# Byte-Serial SPI Master Engine with Status Flags

This block is an 8-bit SPI master placed behind a small byte-wide register port. Software sets the enable bit and picks one of three transfer modes in a control register. It then writes the outgoing byte into a data register and sets a go bit. The engine shifts eight bits, most significant bit first, in SPI mode 0. When the byte is done it clears the go bit by itself. The bytes received from the peripheral are read back through the same data register.

Three status flags report progress. The first shows that a received byte is waiting to be read. The second shows that a written byte has not yet been taken by the shifter. The third latches a collision, which happens when a receiving transfer ends before the previous byte was read. SCLK comes from a fixed divide of the system clock. The engine has no slave mode and no rate prescaler.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, the control register (address 6), data register (address 7) and status register (address 8) all read 0x00, and SCLK and MOSI are both low.
- R2: In mode 00 (control bits 2:1 = 00, full duplex), a transfer started by writing control bit 7 (go) = 1 together with bit 6 (enable) = 1 sends the data-register byte MSB first on MOSI. It also captures the 8 MISO bits into the data register and sets status bit 0 (receive full).
- R3: The go bit reads 1 while a transfer is running and clears by itself when the eighth bit completes. Each transfer gives exactly 8 rising SCLK edges. SCLK idles low, and MOSI is stable while SCLK is high.
- R4: In mode 01 (transmit only), the byte is sent on MOSI, while the received bits are discarded. Receive full stays unchanged and the data register keeps its previous received byte.
- R5: In mode 10 (receive only), MOSI is held at 1 for the whole transfer. The received byte is stored and receive full is set. Status bit 1 (write pending) is not cleared.
- R6: Setting go with mode 11 starts nothing: go reads 0 on the next cycle and SCLK does not toggle.
- R7: Reading the data register clears receive full and leaves the stored byte unchanged.
- R8: A control write that changes enable from 0 to 1 clears receive full.
- R9: Writing the data register sets write pending (status bit 1). Write pending clears when a transfer in mode 00 or 01 starts.
- R10: When a receiving transfer (mode 00 or 10) completes while receive full is 1, status bit 2 (collision) is set and the unread byte is kept. Writing the status register with bit 2 = 0 clears collision.
- R11: Control writes are ignored while a transfer is running. A go bit written while enable is 0 has no effect.
- R12: Each SCLK phase lasts HALF_DIV system clock cycles, so rising edges are 2*HALF_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; side effects on data read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
On every cycle, the embedded assertions check the following: SCLK stays low when idle, MOSI is stable across each SCLK high phase, MOSI is held high in receive-only mode, and go drops after completion and after a reserved-mode request. They also check that receive full and collision rise only on a completion, and that write pending follows a data write. The bench scenarios are the only way to show the values themselves: the bit order on MOSI, the byte captured from MISO, the edge count and spacing, and which flag each mode leaves untouched. They also show the collision keeping the old byte, the enable-edge clear, and control writes ignored during a transfer. These scenarios include a seeded random run over modes, bytes and read/no-read patterns.

// File: rtl/spi_eng_pkg.sv
// Package: shared types and field positions for the SPI shift engine.
// Assumes an 8-bit register port; positions are used by regs and the bench.
package spi_eng_pkg;

    localparam int REG_W = 8;

    // Transfer mode encoding held in control bits 2:1
    typedef enum logic [1:0] {
        XM_DUPLEX = 2'b00,
        XM_TXONLY = 2'b01,
        XM_RXONLY = 2'b10,
        XM_RSVD   = 2'b11
    } xfer_mode_e;

    // Control register field positions
    localparam int CTL_GO      = 7;
    localparam int CTL_EN      = 6;
    localparam int CTL_MODE_HI = 2;
    localparam int CTL_MODE_LO = 1;

    // Status register field positions
    localparam int STS_RXFULL  = 0;
    localparam int STS_TXPEND  = 1;
    localparam int STS_COLL    = 2;

endpackage

// File: rtl/spi_eng_clkgen.sv
// Module: spi_eng_clkgen
// Emits a one-cycle tick every HALF_DIV system cycles while 'run' is high.
// Each tick marks the end of one SCLK phase. The counter restarts whenever run is low.
module spi_eng_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] phase_cnt;

    assign tick = run && (phase_cnt == LAST);

    // Phase counter: counts system cycles within the current SCLK phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cnt <= '0;
        end else if (!run || tick) begin
            phase_cnt <= '0;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    // R12: the phase counter never exceeds the divider limit
    a_r12_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase_cnt <= LAST);

endmodule

// File: rtl/spi_eng_shifter.sv
// Module: spi_eng_shifter
// SPI mode 0 serial shifter, MSB first. A start pulse loads the byte (or all
// ones for receive-only). Each tick toggles SCLK: MISO is sampled on the rise
// and MOSI advances on the fall. After DATA_W bits, done pulses for one cycle.
// Assumes 'mode' stays constant while busy.
module spi_eng_shifter
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_mode_e        mode,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);

    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_tx;
    logic [DATA_W-1:0] sh_rx;
    logic [BW-1:0]     bit_cnt;

    assign mosi    = busy & sh_tx[DATA_W-1];
    assign rx_word = sh_rx;

    // Shift sequencer: load on start, sample on rise, advance on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tx   <= '0;
            sh_rx   <= '0;
            bit_cnt <= '0;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                sclk    <= 1'b0;
                bit_cnt <= '0;
                sh_tx   <= (mode == XM_RXONLY) ? '1 : tx_word;
            end else if (busy && tick) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[DATA_W-2:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    sh_tx <= {sh_tx[DATA_W-2:0], 1'b1};
                    if (bit_cnt == LAST_BIT) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R3: SCLK idles low whenever no transfer is running
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R3: MOSI holds steady across a high SCLK phase
    a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R3: completion is a single-cycle pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: receive-only transfers drive MOSI high throughout
    a_r5_rxonly_mosi_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode == XM_RXONLY) |-> mosi);

endmodule

// File: rtl/spi_eng_regs.sv
// Module: spi_eng_regs
// Register decode and flag logic: control (go/enable/mode), transmit buffer,
// receive buffer and status flags (receive full, write pending, collision).
// Assumes the read data path is combinational and that bus_rd marks a real
// read access, so it may clear flags. Control writes are refused while busy.
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 6,
    parameter int DATA_ADDR = 7,
    parameter int STAT_ADDR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [REG_W-1:0]  rx_word,
    output logic              start_xfer,
    output xfer_mode_e        xfer_mode,
    output logic [REG_W-1:0]  tx_word
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic             go_q;
    logic             en_q;
    xfer_mode_e       mode_q;
    logic [REG_W-1:0] tx_buf;
    logic [REG_W-1:0] rx_buf;
    logic             rx_full;
    logic             tx_pend;
    logic             coll;

    logic sel_ctrl_wr, sel_data_wr, sel_stat_wr, sel_data_rd;
    logic ctrl_wr_ok, en_rise, rx_capture;

    assign sel_ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign sel_data_wr = bus_wr && (bus_addr == A_DATA);
    assign sel_stat_wr = bus_wr && (bus_addr == A_STAT);
    assign sel_data_rd = bus_rd && (bus_addr == A_DATA);

    assign start_xfer  = go_q && en_q && !eng_busy && !eng_done && (mode_q != XM_RSVD);
    assign ctrl_wr_ok  = sel_ctrl_wr && !eng_busy && !eng_done && !start_xfer;
    assign en_rise     = ctrl_wr_ok && bus_wdata[CTL_EN] && !en_q;
    assign rx_capture  = eng_done && (mode_q != XM_TXONLY);

    assign xfer_mode = mode_q;
    assign tx_word   = tx_buf;

    // Read mux: present the addressed register
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[CTL_GO]                  = go_q;
            bus_rdata[CTL_EN]                  = en_q;
            bus_rdata[CTL_MODE_HI:CTL_MODE_LO] = mode_q;
        end else if (bus_addr == A_DATA) begin
            bus_rdata = rx_buf;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[STS_RXFULL] = rx_full;
            bus_rdata[STS_TXPEND] = tx_pend;
            bus_rdata[STS_COLL]   = coll;
        end
    end

    // Control register: software writes, go self-clear on finish or reserved mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            en_q   <= 1'b0;
            mode_q <= XM_DUPLEX;
        end else if (ctrl_wr_ok) begin
            en_q   <= bus_wdata[CTL_EN];
            mode_q <= xfer_mode_e'(bus_wdata[CTL_MODE_HI:CTL_MODE_LO]);
            go_q   <= bus_wdata[CTL_GO] && bus_wdata[CTL_EN];
        end else if (eng_done) begin
            go_q <= 1'b0;
        end else if (go_q && mode_q == XM_RSVD) begin
            go_q <= 1'b0;
        end
    end

    // Transmit side: buffer byte and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_pend <= 1'b0;
        end else if (sel_data_wr) begin
            tx_buf  <= bus_wdata;
            tx_pend <= 1'b1;
        end else if (start_xfer && mode_q != XM_RXONLY) begin
            tx_pend <= 1'b0;
        end
    end

    // Receive side: store a finished byte unless an unread one is waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf  <= '0;
            rx_full <= 1'b0;
        end else if (rx_capture && !rx_full) begin
            rx_buf  <= rx_word;
            rx_full <= 1'b1;
        end else if (sel_data_rd || en_rise) begin
            rx_full <= 1'b0;
        end
    end

    // Collision flag: set on overrun, cleared by writing 0 to its bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll <= 1'b0;
        end else if (rx_capture && rx_full) begin
            coll <= 1'b1;
        end else if (sel_stat_wr && !bus_wdata[STS_COLL]) begin
            coll <= 1'b0;
        end
    end

    // R3: go is low the cycle after the engine reports completion
    a_r3_go_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !go_q);

    // R6: a reserved-mode request is dropped on the next cycle without starting
    a_r6_reserved_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && mode_q == XM_RSVD && !sel_ctrl_wr) |=> (!go_q && !eng_busy));

    // R2: receive full only rises on a transfer completion
    a_r2_rxfull_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(eng_done));

    // R10: collision only rises on a transfer completion
    a_r10_coll_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll) |-> $past(eng_done));

    // R10: the unread byte is not overwritten while receive full is set
    a_r10_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && $past(rx_full)) |-> $stable(rx_buf));

    // R9: a data write leaves write pending set
    a_r9_pend_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        sel_data_wr |=> tx_pend);

    // R11: control fields hold while a transfer runs
    a_r11_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && $past(eng_busy)) |-> ($stable(mode_q) && $stable(en_q)));

endmodule

// File: rtl/spi_shift_engine.sv
// Module: spi_shift_engine (top)
// SPI master byte engine: the register block feeds a mode-0 shifter clocked
// by a fixed divider. Assumes a single master on the bus and that the
// peripheral select is handled outside this block.
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 6,
    parameter int DATA_ADDR = 7,
    parameter int STAT_ADDR = 8,
    parameter int HALF_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic             start_xfer;
    xfer_mode_e       xfer_mode;
    logic [REG_W-1:0] tx_word;
    logic [REG_W-1:0] rx_word;
    logic             eng_busy;
    logic             eng_done;
    logic             tick;

    spi_eng_regs #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .DATA_ADDR(DATA_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .rx_word   (rx_word),
        .start_xfer(start_xfer),
        .xfer_mode (xfer_mode),
        .tx_word   (tx_word)
    );

    spi_eng_clkgen #(
        .HALF_DIV(HALF_DIV)
    ) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (eng_busy),
        .tick (tick)
    );

    spi_eng_shifter #(
        .DATA_W(REG_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_xfer),
        .mode   (xfer_mode),
        .tx_word(tx_word),
        .tick   (tick),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .busy   (eng_busy),
        .done   (eng_done),
        .rx_word(rx_word)
    );

endmodule

// File: tb/spi_shift_engine_bench.sv
// Bench: directed corner cases plus seeded random transfers against a
// behavioural SPI peripheral and a flag model kept in bench variables.
module spi_shift_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int ADDR_W     = 4;
    localparam logic [3:0] A_CTRL = 4'd6;
    localparam logic [3:0] A_DATA = 4'd7;
    localparam logic [3:0] A_STAT = 4'd8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b0;

    int total = 0;
    int bad = 0;

    // peripheral model state
    logic [7:0] slv_sh = '0;
    logic [7:0] slv_rx = '0;
    int         rises = 0;
    int         per_err = 0;
    int         mosi_low = 0;
    time        last_rise = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_shift_engine #(
        .ADDR_W  (ADDR_W),
        .HALF_DIV(HALF_DIV)
    ) u_spi_shift_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso)
    );

    // peripheral: capture MOSI on the rising edge, time the edges
    always @(posedge spi_sclk) begin
        slv_rx = {slv_rx[6:0], spi_mosi};
        if (spi_mosi !== 1'b1) mosi_low++;
        if (rises > 0 && ($time - last_rise) != 2 * HALF_DIV * CLK_PERIOD) per_err++;
        last_rise = $time;
        rises++;
    end

    // peripheral: present the next MISO bit on the falling edge
    always @(negedge spi_sclk) begin
        slv_sh   = {slv_sh[6:0], 1'b0};
        spi_miso = slv_sh[7];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // peek without a read strobe (no side effects)
    task automatic reg_peek(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic prep_slave(input logic [7:0] b);
        slv_sh = b; spi_miso = b[7];
        rises = 0; per_err = 0; mosi_low = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        c = 8'h80;
        for (int i = 0; i < 400 && c[7]; i++) reg_peek(A_CTRL, c);
    endtask

    // expected control byte for en=1, given mode
    function automatic logic [7:0] ctl_byte(input logic go, input logic [1:0] m);
        return {go, 1'b1, 3'b000, m, 1'b0};
    endfunction

    function automatic logic [7:0] sts_byte(input logic f, input logic p, input logic c);
        return {5'b0, c, p, f};
    endfunction

    // bench flag model
    logic [7:0] m_buf = '0;
    logic       m_full = 0, m_pend = 0, m_coll = 0;
    logic [7:0] m_tx = '0;

    function automatic logic [7:0] slave_sees(input logic [1:0] m, input logic [7:0] tx);
        return (m == 2'b10) ? 8'hFF : tx;
    endfunction

    task automatic model_done(input logic [1:0] m, input logic [7:0] sb);
        if (m != 2'b01) begin
            if (m_full) m_coll = 1'b1;
            else begin m_buf = sb; m_full = 1'b1; end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_peek(A_CTRL, r); chk("R1 ctrl", r, 8'h00);
        reg_peek(A_DATA, r); chk("R1 data", r, 8'h00);
        reg_peek(A_STAT, r); chk("R1 stat", r, 8'h00);
        chk("R1 sclk", spi_sclk, 1'b0);
        chk("R1 mosi", spi_mosi, 1'b0);

        // R2/R3/R12: full duplex transfer
        reg_wr(A_CTRL, 8'h40);
        reg_wr(A_DATA, 8'hA5);
        reg_peek(A_STAT, r); chk("R9 pend after write", r, sts_byte(0, 1, 0));
        prep_slave(8'h3C);
        reg_wr(A_CTRL, 8'hC0);
        reg_peek(A_CTRL, r); chk("R3 go reads 1 while running", r[7], 1'b1);
        wait_idle();
        chk("R2 mosi byte", slv_rx, 8'hA5);
        chk("R3 eight rises", rises, 8);
        chk("R12 rise spacing", per_err, 0);
        reg_peek(A_CTRL, r); chk("R3 go self-clears", r, ctl_byte(0, 2'b00));
        reg_peek(A_STAT, r); chk("R2 rx full, R9 pend cleared", r, sts_byte(1, 0, 0));
        reg_rd(A_DATA, r); chk("R2 miso byte", r, 8'h3C);
        reg_peek(A_STAT, r); chk("R7 read clears full", r, sts_byte(0, 0, 0));
        reg_peek(A_DATA, r); chk("R7 byte kept", r, 8'h3C);

        // R4: transmit only
        reg_wr(A_DATA, 8'h5A);
        prep_slave(8'hF0);
        reg_wr(A_CTRL, 8'hC2);
        wait_idle();
        chk("R4 mosi byte", slv_rx, 8'h5A);
        reg_peek(A_STAT, r); chk("R4 full untouched", r, sts_byte(0, 0, 0));
        reg_peek(A_DATA, r); chk("R4 old byte kept", r, 8'h3C);

        // R5: receive only, pending survives
        reg_wr(A_DATA, 8'h77);
        prep_slave(8'h96);
        reg_wr(A_CTRL, 8'hC4);
        wait_idle();
        chk("R5 mosi all ones", mosi_low, 0);
        chk("R5 slave saw ff", slv_rx, 8'hFF);
        reg_peek(A_STAT, r); chk("R5 full set, R9 pend kept", r, sts_byte(1, 1, 0));
        reg_peek(A_DATA, r); chk("R5 rx byte", r, 8'h96);

        // R10: collision with unread byte
        prep_slave(8'h99);
        reg_wr(A_CTRL, 8'hC0);
        wait_idle();
        reg_peek(A_STAT, r); chk("R10 coll set", r, sts_byte(1, 0, 1));
        reg_peek(A_DATA, r); chk("R10 unread kept", r, 8'h96);
        reg_wr(A_STAT, 8'h00);
        reg_peek(A_STAT, r); chk("R10 coll cleared", r, sts_byte(1, 0, 0));

        // R8: enable edge clears full
        reg_wr(A_CTRL, 8'h00);
        reg_peek(A_STAT, r); chk("R8 full held while disabled", r[0], 1'b1);
        reg_wr(A_CTRL, 8'h40);
        reg_peek(A_STAT, r); chk("R8 full cleared on enable", r[0], 1'b0);

        // R6: reserved mode
        prep_slave(8'h00);
        reg_wr(A_CTRL, 8'hC6);
        reg_peek(A_CTRL, r); chk("R6 go dropped", r, ctl_byte(0, 2'b11));
        repeat (20) @(negedge clk);
        chk("R6 no sclk", rises, 0);

        // R11: go without enable
        reg_wr(A_CTRL, 8'h80);
        reg_peek(A_CTRL, r); chk("R11 go ignored when disabled", r, 8'h00);
        repeat (20) @(negedge clk);
        chk("R11 no sclk when disabled", rises, 0);

        // R11: control write during a transfer
        reg_wr(A_CTRL, 8'h40);
        reg_wr(A_DATA, 8'hC3);
        prep_slave(8'h12);
        reg_wr(A_CTRL, 8'hC0);
        repeat (4) @(negedge clk);
        reg_wr(A_CTRL, 8'h04);
        wait_idle();
        reg_peek(A_CTRL, r); chk("R11 busy write ignored", r, ctl_byte(0, 2'b00));
        chk("R11 transfer intact", slv_rx, 8'hC3);
        reg_rd(A_DATA, r); chk("R2 miso byte 2", r, 8'h12);
        reg_wr(A_STAT, 8'h00);

        // seeded random transfers against the model
        m_buf = 8'h12; m_full = 0; m_pend = 0; m_coll = 0; m_tx = 8'hC3;
        for (int it = 0; it < 24; it++) begin
            logic [1:0] m;
            logic [7:0] sb;
            m  = 2'($urandom_range(0, 2));
            sb = 8'($urandom);
            if ($urandom_range(0, 3) != 0) begin
                m_tx = 8'($urandom);
                reg_wr(A_DATA, m_tx);
                m_pend = 1'b1;
            end
            prep_slave(sb);
            reg_wr(A_CTRL, ctl_byte(1, m));
            if (m != 2'b10) m_pend = 1'b0;
            wait_idle();
            model_done(m, sb);
            chk("R2 random mosi", slv_rx, slave_sees(m, m_tx));
            chk("R3 random rises", rises, 8);
            reg_peek(A_STAT, r); chk("R10 random status", r, sts_byte(m_full, m_pend, m_coll));
            reg_peek(A_DATA, r); chk("R4 random data", r, m_buf);
            if ($urandom_range(0, 2) != 0) begin
                reg_rd(A_DATA, r);
                m_full = 1'b0;
            end
            if (m_coll && $urandom_range(0, 1) == 1) begin
                reg_wr(A_STAT, 8'h00);
                m_coll = 1'b0;
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule